// File: doc/BRIEF.md
# Flash Protection Guard and Vector Remapper

This block sits beside a flash command processor and the CPU fetch path. It holds an 8-bit protection setting. Bits 7..1 of that setting pick a 512-byte boundary. Bit 0 turns protection off when it is 1. Every address from the boundary up to 0xFFFF is treated as locked. A program, page erase or mass erase request is checked against this setting. The result comes back one cycle later as either a launch pulse or a violation pulse, never both.

The setting is copied from a nonvolatile byte while reset is held. A redirect-disable option bit is copied at the same time. After that, only writes that come from the debug port change the setting. Writes from application code leave it untouched.

When redirection is allowed and only part of flash is locked, vector fetches in 0xFFC0..0xFFFD are steered to the 64 bytes just below the locked region. This lets an unlocked image supply its own interrupt vectors. The reset vector at 0xFFFE..0xFFFF always stays in place.

Top module: `nvm_guard`

## Requirements
- R1: While `rstN` is 0, the protection setting is loaded from `bootProtByte` and the redirect-disable option from `bootNoRedir`. Both are in force from the first cycle after reset.
- R2: A write with `wrEn`=1 and `wrIsDebug`=0 has no effect. A write with `wrEn`=1 and `wrIsDebug`=1 replaces the setting with `wrData`, and the new value is in force from the next cycle.
- R3: Protection is active only when setting bit 0 is 0 and bits 7..1 are not all ones. When it is inactive, no command is ever reported as a violation.
- R4: The first locked address is {setting[7:1], 9'h1FF} + 1. A program (`cmdKind`=1) or page erase (`cmdKind`=2) whose `cmdAddr` is at or above that address, with protection active, gives `cmdViolation`=1 one cycle after `cmdValid`.
- R5: A mass erase (`cmdKind`=3) is a violation whenever protection is active. A blank check (`cmdKind`=0) is never a violation.
- R6: For each cycle with `cmdValid`=1, exactly one of `cmdLaunch` and `cmdViolation` is 1 in the following cycle. Both are 0 after a cycle without `cmdValid`.
- R7: Redirection is on only when the option bit is 0, protection is active, and the first locked address is above `FLASH_BASE` (0xF800), i.e. part of flash is still open.
- R8: With redirection on, a fetch with `fetchIsVector`=1 and an address in 0xFFC0..0xFFFD gives `fetchAddrOut` = firstLocked − 0x40 + (addr − 0xFFC0) in the same cycle. For example, setting 0xFA maps 0xFFC0 to 0xFBC0.
- R9: Addresses 0xFFFE and 0xFFFF, and every fetch with `fetchIsVector`=0, pass through to `fetchAddrOut` unchanged.
- R10: Setting 0xDE locks 0xE000..0xFFFF: a program at 0xDFFF launches and a program at 0xE000 is a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; loads the boot values |
| bootProtByte | input | 8 | Nonvolatile protection byte copied during reset |
| bootNoRedir | input | 1 | Nonvolatile redirect-disable bit copied during reset |
| wrEn | input | 1 | Write strobe for the protection setting |
| wrIsDebug | input | 1 | 1 when the write comes from the debug port |
| wrData | input | 8 | New protection setting |
| cmdValid | input | 1 | A command is being launched this cycle |
| cmdKind | input | 2 | 0 blank check, 1 program, 2 page erase, 3 mass erase |
| cmdAddr | input | 16 | Target address of the command |
| fetchAddr | input | 16 | CPU fetch address |
| fetchIsVector | input | 1 | Fetch is a vector read |
| cmdLaunch | output | 1 | Command accepted (one cycle after `cmdValid`) |
| cmdViolation | output | 1 | Command refused by protection (one cycle after `cmdValid`) |
| fetchAddrOut | output | 16 | Fetch address after vector redirection |

## Verification
A corrupted protection setting does not stay hidden for long. It shows up the next time a command hits the wrong side of the boundary, as a launch where a violation was due or the other way round. It also shows up at once as a wrong `fetchAddrOut` on any vector fetch while redirection is on. A stale redirect-disable bit shows up as vectors that move when they should stay put, or stay put when they should move. For that reason the bench compares the verdict outputs and the remapped address against a behavioural model on every clock, while traffic mixes debug and application writes. A wrong setting is therefore caught within a cycle of the first access that depends on it.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  typedef enum logic [1:0] {
    CMD_BLANK = 2'd0,
    CMD_PROG  = 2'd1,
    CMD_PAGE  = 2'd2,
    CMD_MASS  = 2'd3
  } cmdKind_e;

  typedef struct packed {
    logic loadBoot;
    logic loadDebug;
  } guardStrobe_t;
endpackage

// File: rtl/nvm_guard_dp.sv
module nvm_guard_dp
  import nvm_guard_pkg::*;
#(
  parameter int unsigned SEL_W      = 7,
  parameter int unsigned PAGE_BITS  = 9,
  parameter int unsigned VEC_SPAN   = 64,
  parameter int unsigned VEC_BASE   = 'hFFC0,
  parameter int unsigned VEC_LAST   = 'hFFFD,
  parameter int unsigned FLASH_BASE = 'hF800,
  localparam int unsigned ADDR_W    = SEL_W + PAGE_BITS,
  localparam int unsigned REG_W     = SEL_W + 1
) (
  input  logic              clk,
  input  guardStrobe_t      strobe,
  input  logic [REG_W-1:0]  bootProtByte,
  input  logic              bootNoRedir,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchIsVector,
  output logic              protActive,
  output logic [ADDR_W:0]   firstProt,
  output logic [ADDR_W-1:0] fetchAddrOut
);
  localparam int unsigned VEC_W = $clog2(VEC_SPAN);
  localparam logic [ADDR_W-1:0] VEC_LO  = VEC_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] VEC_HI  = VEC_LAST[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] SPAN_A  = VEC_SPAN[ADDR_W-1:0];
  localparam logic [ADDR_W:0]   FLASH_LO = {1'b0, FLASH_BASE[ADDR_W-1:0]};
  localparam logic [ADDR_W:0]   PAGE_STEP = {{SEL_W{1'b0}}, 1'b1, {PAGE_BITS{1'b0}}};

  logic [REG_W-1:0] protCfg;
  logic             noRedirQ;
  logic [SEL_W-1:0] selBits;
  logic             allProt;
  logic             redirOn;
  logic             inVec;
  logic [ADDR_W-1:0] vecOffset;

  always_ff @(posedge clk) begin
    if (strobe.loadBoot) begin
      protCfg  <= bootProtByte;
      noRedirQ <= bootNoRedir;
    end else if (strobe.loadDebug) begin
      protCfg  <= wrData;
    end
  end

  always_comb begin
    selBits    = protCfg[REG_W-1:1];
    protActive = !protCfg[0] && (selBits != '1);
    firstProt  = {1'b0, selBits, {PAGE_BITS{1'b0}}} + PAGE_STEP;
    allProt    = firstProt <= FLASH_LO;
    redirOn    = !noRedirQ && protActive && !allProt;
    inVec      = fetchIsVector && (fetchAddr >= VEC_LO) && (fetchAddr <= VEC_HI);
    vecOffset  = {{(ADDR_W-VEC_W){1'b0}}, fetchAddr[VEC_W-1:0]};
    if (redirOn && inVec)
      fetchAddrOut = firstProt[ADDR_W-1:0] - SPAN_A + vecOffset;
    else
      fetchAddrOut = fetchAddr;
  end
endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrIsDebug,
  input  logic              cmdValid,
  input  cmdKind_e          cmdKind,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              protActive,
  input  logic [ADDR_W:0]   firstProt,
  output guardStrobe_t      strobe,
  output logic              cmdLaunch,
  output logic              cmdViolation
);
  logic targetLocked;
  logic hit;

  always_comb begin
    strobe.loadBoot  = !rstN;
    strobe.loadDebug = rstN && wrEn && wrIsDebug;
    targetLocked = ({1'b0, cmdAddr} >= firstProt) &&
                   ((cmdKind == CMD_PROG) || (cmdKind == CMD_PAGE));
    hit = protActive && (targetLocked || (cmdKind == CMD_MASS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdLaunch    <= 1'b0;
      cmdViolation <= 1'b0;
    end else begin
      cmdLaunch    <= cmdValid && !hit;
      cmdViolation <= cmdValid && hit;
    end
  end
endmodule

// File: rtl/nvm_guard.sv
module nvm_guard
  import nvm_guard_pkg::*;
#(
  parameter int unsigned SEL_W      = 7,
  parameter int unsigned PAGE_BITS  = 9,
  parameter int unsigned VEC_SPAN   = 64,
  parameter int unsigned VEC_BASE   = 'hFFC0,
  parameter int unsigned VEC_LAST   = 'hFFFD,
  parameter int unsigned FLASH_BASE = 'hF800,
  localparam int unsigned ADDR_W    = SEL_W + PAGE_BITS,
  localparam int unsigned REG_W     = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  bootProtByte,
  input  logic              bootNoRedir,
  input  logic              wrEn,
  input  logic              wrIsDebug,
  input  logic [REG_W-1:0]  wrData,
  input  logic              cmdValid,
  input  logic [1:0]        cmdKind,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchIsVector,
  output logic              cmdLaunch,
  output logic              cmdViolation,
  output logic [ADDR_W-1:0] fetchAddrOut
);
  guardStrobe_t      strobe;
  logic              protActive;
  logic [ADDR_W:0]   firstProt;

  nvm_guard_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIsDebug(wrIsDebug),
    .cmdValid(cmdValid), .cmdKind(cmdKind_e'(cmdKind)), .cmdAddr(cmdAddr),
    .protActive(protActive), .firstProt(firstProt),
    .strobe(strobe), .cmdLaunch(cmdLaunch), .cmdViolation(cmdViolation)
  );

  nvm_guard_dp #(
    .SEL_W(SEL_W), .PAGE_BITS(PAGE_BITS), .VEC_SPAN(VEC_SPAN),
    .VEC_BASE(VEC_BASE), .VEC_LAST(VEC_LAST), .FLASH_BASE(FLASH_BASE)
  ) u_dp (
    .clk(clk), .strobe(strobe), .bootProtByte(bootProtByte),
    .bootNoRedir(bootNoRedir), .wrData(wrData), .fetchAddr(fetchAddr),
    .fetchIsVector(fetchIsVector), .protActive(protActive),
    .firstProt(firstProt), .fetchAddrOut(fetchAddrOut)
  );
endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrIsDebug,
  input logic              cmdValid,
  input logic [1:0]        cmdKind,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchIsVector,
  input logic              cmdLaunch,
  input logic              cmdViolation,
  input logic [ADDR_W-1:0] fetchAddrOut,
  input logic              protActive,
  input logic [ADDR_W:0]   firstProt
);
  // R2
  app_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrIsDebug) |=> ($stable(firstProt) && $stable(protActive)));

  // R3
  inactive_no_viol_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !protActive) |=> !cmdViolation);

  // R5
  blank_never_viol_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 2'd0) |=> (cmdLaunch && !cmdViolation));

  // R6
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdLaunch && cmdViolation));

  // R6
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> $countones({cmdLaunch, cmdViolation}) == 1);

  // R6
  verdict_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (!cmdLaunch && !cmdViolation));

  // R9
  reset_vec_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchAddr[ADDR_W-1:1] == '1) |-> (fetchAddrOut == fetchAddr));

  // R9
  non_vector_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fetchIsVector |-> (fetchAddrOut == fetchAddr));
endmodule

bind nvm_guard nvm_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIsDebug(wrIsDebug),
  .cmdValid(cmdValid), .cmdKind(cmdKind), .fetchAddr(fetchAddr),
  .fetchIsVector(fetchIsVector), .cmdLaunch(cmdLaunch),
  .cmdViolation(cmdViolation), .fetchAddrOut(fetchAddrOut),
  .protActive(protActive), .firstProt(firstProt)
);

// File: tb/test_nvm_guard.sv
`timescale 1ns/1ps
module test_nvm_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  bootProtByte = 8'hFC;
  logic        bootNoRedir = 1'b0;
  logic        wrEn = 1'b0, wrIsDebug = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdKind = 2'd0;
  logic [15:0] cmdAddr = 16'h0000;
  logic [15:0] fetchAddr = 16'h0000;
  logic        fetchIsVector = 1'b0;
  logic        cmdLaunch, cmdViolation;
  logic [15:0] fetchAddrOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int refProt = 0;
  int refNoRedir = 0;
  bit expL = 0, expV = 0;

  always #2.5 clk = ~clk;

  nvm_guard i_nvm_guard (
    .clk(clk), .rstN(rstN), .bootProtByte(bootProtByte), .bootNoRedir(bootNoRedir),
    .wrEn(wrEn), .wrIsDebug(wrIsDebug), .wrData(wrData), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr), .fetchAddr(fetchAddr),
    .fetchIsVector(fetchIsVector), .cmdLaunch(cmdLaunch),
    .cmdViolation(cmdViolation), .fetchAddrOut(fetchAddrOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int firstLocked(input int p);
    return (p / 2) * 512 + 512;
  endfunction

  function automatic bit isActive(input int p);
    return (p % 2 == 0) && (p / 2 != 127);
  endfunction

  function automatic int remap(input int p, input int nr, input int a, input bit v);
    bit redir;
    redir = (nr == 0) && isActive(p) && (firstLocked(p) > 'hF800);
    if (redir && v && a >= 'hFFC0 && a <= 'hFFFD)
      return firstLocked(p) - 64 + (a - 'hFFC0);
    return a;
  endfunction

  function automatic bit violates(input int p, input int k, input int a);
    if (!isActive(p)) return 0;
    if (k == 3) return 1;
    if ((k == 1 || k == 2) && a >= firstLocked(p)) return 1;
    return 0;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      refProt = bootProtByte;
      refNoRedir = bootNoRedir;
      expL = 0;
      expV = 0;
    end else begin
      expV = cmdValid && violates(refProt, cmdKind, cmdAddr);
      expL = cmdValid && !violates(refProt, cmdKind, cmdAddr);
      if (wrEn && wrIsDebug) refProt = wrData;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      #0.5;
      chk(cmdViolation == expV, "R4 verdict violation", cmdViolation, expV);
      chk(cmdLaunch == expL, "R6 verdict launch", cmdLaunch, expL);
      chk(fetchAddrOut == 16'(remap(refProt, refNoRedir, fetchAddr, fetchIsVector)),
          "R8 remap", fetchAddrOut, remap(refProt, refNoRedir, fetchAddr, fetchIsVector));
    end
  end

  task automatic doReset(input logic [7:0] b, input logic nr);
    @(negedge clk);
    rstN = 0; bootProtByte = b; bootNoRedir = nr;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic regWrite(input logic [7:0] v, input logic dbg);
    @(negedge clk);
    wrEn = 1; wrIsDebug = dbg; wrData = v;
    @(negedge clk);
    wrEn = 0; wrIsDebug = 0;
  endtask

  task automatic runCmd(input logic [1:0] k, input logic [15:0] a,
                        input bit eL, input bit eV, input string tag);
    @(negedge clk);
    cmdValid = 1; cmdKind = k; cmdAddr = a;
    @(negedge clk);
    #1;
    chk(cmdLaunch == eL, tag, cmdLaunch, eL);
    chk(cmdViolation == eV, tag, cmdViolation, eV);
    cmdValid = 0;
  endtask

  task automatic fetchChk(input logic [15:0] a, input bit v,
                          input logic [15:0] e, input string tag);
    @(negedge clk);
    fetchAddr = a; fetchIsVector = v;
    #1;
    chk(fetchAddrOut == e, tag, fetchAddrOut, e);
  endtask

  initial begin
    doReset(8'hFC, 1'b0);
    @(negedge clk); #1;
    chk(cmdLaunch == 0 && cmdViolation == 0, "R1 reset outputs idle",
        {cmdLaunch, cmdViolation}, 0);
    fetchChk(16'hFFE0, 1, 16'hFDE0, "R1 boot setting drives remap");
    runCmd(2'd1, 16'hFE00, 0, 1, "R1 boot setting locks FE00");
    regWrite(8'hFF, 0);
    fetchChk(16'hFFE0, 1, 16'hFDE0, "R2 application write ignored");
    runCmd(2'd1, 16'hFFFF, 0, 1, "R2 application write ignored lock");
    regWrite(8'hFF, 1);
    fetchChk(16'hFFE0, 1, 16'hFFE0, "R3 disable bit set no remap");
    runCmd(2'd3, 16'h0000, 1, 0, "R3 disable bit mass erase launches");
    regWrite(8'hFE, 1);
    runCmd(2'd1, 16'hFFFF, 1, 0, "R3 all-ones selector protects nothing");
    regWrite(8'hDE, 1);
    runCmd(2'd1, 16'hDFFF, 1, 0, "R10 DFFF open");
    runCmd(2'd1, 16'hE000, 0, 1, "R10 E000 locked");
    runCmd(2'd2, 16'hF123, 0, 1, "R4 page erase in locked region");
    runCmd(2'd2, 16'h1000, 1, 0, "R4 page erase below boundary");
    runCmd(2'd3, 16'h0000, 0, 1, "R5 mass erase while locked");
    runCmd(2'd0, 16'hFFFF, 1, 0, "R5 blank check never refused");
    fetchChk(16'hFFE0, 1, 16'hFFE0, "R7 all flash locked no remap");
    regWrite(8'hFA, 1);
    fetchChk(16'hFFC0, 1, 16'hFBC0, "R8 lowest vector");
    fetchChk(16'hFFFD, 1, 16'hFBFD, "R8 highest vector");
    fetchChk(16'hFFFE, 1, 16'hFFFE, "R9 reset vector fixed");
    fetchChk(16'hFFE0, 0, 16'hFFE0, "R9 non-vector fetch passes");
    doReset(8'hFC, 1'b1);
    fetchChk(16'hFFE0, 1, 16'hFFE0, "R7 option bit blocks remap");
    doReset(8'hFC, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cmdValid = ($urandom % 2) == 0;
      cmdKind = 2'($urandom);
      cmdAddr = ($urandom % 2) ? 16'($urandom) : 16'hF000 | 16'($urandom % 'h1000);
      wrEn = ($urandom % 6) == 0;
      wrIsDebug = $urandom % 2;
      case ($urandom % 8)
        0: wrData = 8'hFC; 1: wrData = 8'hFA; 2: wrData = 8'hDE; 3: wrData = 8'hFE;
        4: wrData = 8'hFF; 5: wrData = 8'hF0; 6: wrData = 8'hFB; default: wrData = 8'($urandom);
      endcase
      fetchAddr = ($urandom % 2) ? 16'hFFC0 + 16'($urandom % 64) : 16'($urandom);
      fetchIsVector = $urandom % 2;
    end
    @(negedge clk);
    cmdValid = 0; wrEn = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule